// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit takes level-sensitive interrupt lines from two sources and presents at most one pending vectored interrupt to a processor core at a time. The first source is a bank of direct vector lines, one per vector number, coming from the I/O bridge. The second source is a 16-line legacy ISA interrupt bus. Five of the ISA lines translate to fixed vector numbers. The other ISA lines are dropped.

The two sources are ORed per vector. A rising level on a vector is a raise event and a falling level is a lower event. The unit holds one mailbox slot. When the slot is empty, a raise fills it. The unit then sets a busy flag, asserts a hard request with the vectored-interrupt trap index, pulses a wake signal so that a halted core resumes, and composes three data words. Raises that arrive while the slot is full are lost. The slot empties when the line that filled it goes low again. Software reads the data words and a status word through a small combinational register port.

Top module: `vd_dispatch`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: busy is 0, hard_req is 0, trap_idx is 0, wake is 0, and all three data words and the status word read 0.
- R2: A rising level on direct line v (0 to 47) while the unit is idle sets busy on the next clock edge. Data word 0 (register address 0) then reads 0x7C0 | v, which is 0x1F in bits 10:6 and v in bits 5:0.
- R3: Each accepted raise clears data word 1 (address 1) and data word 2 (address 2). Address 3 returns the status word, with busy in bit 5 and 0 in every other bit.
- R4: ISA lines map to vectors as follows: line 7 to 0x22, line 6 to 0x27, line 1 to 0x29, line 12 to 0x2A and line 4 to 0x2B. Each mapped line then behaves like the matching direct line.
- R5: A raise on any other ISA line has no effect: busy stays 0.
- R6: A raise that arrives while busy is lost. Data word 0 does not change, and that raise is not taken later.
- R7: The held vector going low clears busy and hard_req on the next edge. Other lines going low have no effect.
- R8: While busy, hard_req is 1 and trap_idx is 0x060. While idle, both read 0.
- R9: wake is a one-cycle pulse on the cycle in which a raise is accepted.
- R10: When several vectors rise in the same cycle while idle, the lowest vector number is accepted and the others are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_lines | input | 48 | Direct vector interrupt levels |
| isa_lines | input | 16 | Legacy ISA interrupt levels |
| rd_addr | input | 2 | Register select: 0 to 2 for the data words, 3 for status |
| rd_data | output | 64 | Selected register value |
| busy | output | 1 | Mailbox holds a vector |
| hard_req | output | 1 | Hard interrupt request to the core |
| trap_idx | output | 9 | Trap index presented to the core |
| wake | output | 1 | One-cycle pulse that wakes a halted core |

## Verification
Every one of the 48 direct lines is raised and lowered alone. This shows that each vector number lands in the low bits of data word 0 and that the held line releases the slot. All 16 ISA lines are then swept one at a time, which separates the five translated lines from the discarded ones and checks each translated vector number. Overlapping raises show that a raise while busy is lost and that only the held line can clear the slot. A burst of three vectors rising in the same cycle shows that the lowest number wins and that the losers are not replayed.

// File: rtl/vd_pkg.sv
// Shared constants and the fixed ISA-to-vector translation for the
// vectored interrupt dispatch unit. Assumes the ISA bus has 16 lines.
package vd_pkg;
    localparam int ISA_N      = 16;
    localparam int MARK_SHIFT = 6;
    localparam logic [4:0] MARK = 5'h1F;

    typedef struct packed {
        logic       valid;
        logic [7:0] vec;
    } isa_map_t;

    // Fixed sparse translation; unmapped lines return valid = 0
    function automatic isa_map_t isa_to_vec(input int line);
        isa_map_t m;
        m.valid = 1'b1;
        case (line)
            7:       m.vec = 8'h22;
            6:       m.vec = 8'h27;
            1:       m.vec = 8'h29;
            12:      m.vec = 8'h2A;
            4:       m.vec = 8'h2B;
            default: begin m.valid = 1'b0; m.vec = 8'h00; end
        endcase
        return m;
    endfunction
endpackage

// File: rtl/vd_isa_xlate.sv
// Merges the ISA lines onto the vector lines through the fixed
// translation. Purely combinational; assumes every mapped vector is
// below NUM_VEC.
module vd_isa_xlate #(
    parameter int NUM_VEC = 48
) (
    input  logic [NUM_VEC-1:0]        vec_lines,
    input  logic [vd_pkg::ISA_N-1:0]  isa_lines,
    output logic [NUM_VEC-1:0]        merged
);
    // ORs each mapped ISA line into the vector it translates to
    always_comb begin
        merged = vec_lines;
        for (int n = 0; n < vd_pkg::ISA_N; n++) begin
            if (vd_pkg::isa_to_vec(n).valid && isa_lines[n])
                merged[vd_pkg::isa_to_vec(n).vec] = 1'b1;
        end
    end
endmodule

// File: rtl/vd_edge.sv
// Registers each merged level and flags the lines that rose this cycle.
// Assumes the inputs are already synchronous to clk.
module vd_edge #(
    parameter int NUM_VEC = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] level,
    output logic [NUM_VEC-1:0] rise
);
    logic [NUM_VEC-1:0] prev_q;

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_line
        // Holds the previous level of line i
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= level[i];
        end
        assign rise[i] = level[i] & ~prev_q[i];
    end
endmodule

// File: rtl/vd_lowest_pick.sv
// Selects the lowest-numbered requesting vector. Combinational; the
// grant vector is one-hot or zero.
module vd_lowest_pick #(
    parameter int NUM_VEC = 48,
    localparam int VEC_W = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    output logic               any,
    output logic [VEC_W-1:0]   idx,
    output logic [NUM_VEC-1:0] grant
);
    // Scans downward so that the lowest set index is the one kept
    always_comb begin
        idx   = '0;
        grant = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = VEC_W'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
        any = |req;
    end

    // R10: no more than one vector is granted
    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R10: a grant is given exactly when some request is present
    assert_grant_when_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ($countones(grant) == 1));
endmodule

// File: rtl/vd_mailbox.sv
// Single-slot mailbox: accepts one vector when idle, composes the data
// words, raises the request and wake, and releases when the held line
// drops. Assumes level reflects the merged interrupt levels.
module vd_mailbox #(
    parameter int NUM_VEC = 48,
    parameter int DATA_W  = 64,
    parameter int TRAP_W  = 9,
    parameter logic [TRAP_W-1:0] TRAP_IVEC = 9'h060,
    localparam int VEC_W = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] level,
    input  logic               rise_any,
    input  logic [VEC_W-1:0]   rise_vec,
    output logic               busy,
    output logic               hard_req,
    output logic [TRAP_W-1:0]  trap_idx,
    output logic               wake,
    output logic [DATA_W-1:0]  word0,
    output logic [DATA_W-1:0]  word1,
    output logic [DATA_W-1:0]  word2
);
    logic             busy_q, wake_q;
    logic [VEC_W-1:0] held_q;
    logic             accept, release_slot;

    assign accept       = rise_any && !busy_q;
    assign release_slot = busy_q && !level[held_q];

    // Slot state: fill on an idle raise, empty when the held line drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            held_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            held_q <= rise_vec;
        end else if (release_slot) begin
            busy_q <= 1'b0;
        end
    end

    // Data words composed on acceptance and kept until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= '0;
            word1 <= '0;
            word2 <= '0;
        end else if (accept) begin
            word0 <= DATA_W'({vd_pkg::MARK, {(vd_pkg::MARK_SHIFT - VEC_W){1'b0}}, rise_vec});
            word1 <= '0;
            word2 <= '0;
        end
    end

    // One-cycle wake pulse per accepted raise
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= accept;
    end

    assign busy     = busy_q;
    assign hard_req = busy_q;
    assign trap_idx = busy_q ? TRAP_IVEC : '0;
    assign wake     = wake_q;

    // R2: an idle raise fills the slot on the next edge
    assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_any && !busy) |=> busy);
    // R6: while the held line stays high the slot and word 0 do not change
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && level[held_q]) |=> (busy && $stable(word0)));
    // R7: the held line dropping empties the slot
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !level[held_q]) |=> !busy);
    // R9: wake appears only right after the slot filled
    assert_wake_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> busy);
    // R3: a newly filled slot has cleared auxiliary words
    assert_aux_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (word1 == '0 && word2 == '0));
endmodule

// File: rtl/vd_dispatch.sv
// Top of the vectored interrupt dispatch unit: merges the ISA lines
// onto the vector lines, detects raises, picks the lowest vector, and
// feeds the single-slot mailbox. The register port is combinational.
module vd_dispatch #(
    parameter int NUM_VEC = 48,
    parameter int DATA_W  = 64,
    parameter int TRAP_W  = 9,
    parameter logic [TRAP_W-1:0] TRAP_IVEC = 9'h060,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VEC-1:0]       vec_lines,
    input  logic [vd_pkg::ISA_N-1:0] isa_lines,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     hard_req,
    output logic [TRAP_W-1:0]        trap_idx,
    output logic                     wake
);
    logic [NUM_VEC-1:0] merged, rise, grant;
    logic               rise_any;
    logic [VEC_W-1:0]   rise_vec;
    logic [DATA_W-1:0]  word0, word1, word2;

    vd_isa_xlate #(.NUM_VEC(NUM_VEC)) u_xlate (
        .vec_lines(vec_lines), .isa_lines(isa_lines), .merged(merged));

    vd_edge #(.NUM_VEC(NUM_VEC)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(merged), .rise(rise));

    vd_lowest_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(rise),
        .any(rise_any), .idx(rise_vec), .grant(grant));

    vd_mailbox #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .TRAP_W(TRAP_W),
                 .TRAP_IVEC(TRAP_IVEC)) u_box (
        .clk(clk), .rst_n(rst_n), .level(merged),
        .rise_any(rise_any), .rise_vec(rise_vec),
        .busy(busy), .hard_req(hard_req), .trap_idx(trap_idx), .wake(wake),
        .word0(word0), .word1(word1), .word2(word2));

    // Register read mux: three data words and the status word
    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = word0;
            2'd1:    rd_data = word1;
            2'd2:    rd_data = word2;
            default: rd_data = DATA_W'({busy, 5'b0_0000});
        endcase
    end

    // R8: the request and the trap index follow the slot state
    assert_req_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req == (trap_idx == TRAP_IVEC));
    // R3: the status word carries busy in bit 5
    assert_status_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd3) |-> (rd_data[5] == hard_req));
endmodule

// File: tb/vd_dispatch_bench.sv
module vd_dispatch_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [47:0] vec_lines = '0;
    logic [15:0] isa_lines = '0;
    logic [1:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        busy, hard_req, wake;
    logic [8:0]  trap_idx;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    vd_dispatch u_vd_dispatch (
        .clk(clk), .rst_n(rst_n), .vec_lines(vec_lines), .isa_lines(isa_lines),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .hard_req(hard_req),
        .trap_idx(trap_idx), .wake(wake));

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic read(input logic [1:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_held(input string tag, input int v);
        logic [63:0] d;
        check({tag, " busy"}, 64'(busy), 64'd1);
        check({tag, " R8 req"}, 64'(hard_req), 64'd1);
        check({tag, " R8 trap"}, 64'(trap_idx), 64'h060);
        read(2'd0, d); check({tag, " word0"}, d, 64'h7C0 | 64'(v));
        read(2'd1, d); check({tag, " R3 word1"}, d, 64'd0);
        read(2'd2, d); check({tag, " R3 word2"}, d, 64'd0);
        read(2'd3, d); check({tag, " R3 status"}, d, 64'h20);
    endtask

    task automatic check_idle(input string tag);
        logic [63:0] d;
        check({tag, " idle busy"}, 64'(busy), 64'd0);
        check({tag, " R8 idle req"}, 64'(hard_req), 64'd0);
        check({tag, " R8 idle trap"}, 64'(trap_idx), 64'd0);
        read(2'd3, d); check({tag, " idle status"}, d, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] d;
        int isa_vec;
        repeat (3) tick();
        // R1: reset state
        check("R1 busy", 64'(busy), 0);
        check("R1 wake", 64'(wake), 0);
        check_idle("R1");
        for (int a = 0; a < 3; a++) begin
            read(2'(a), d); check("R1 word", d, 0);
        end
        rst_n = 1;
        tick();

        // R2/R7/R9: sweep every direct line
        for (int v = 0; v < 48; v++) begin
            vec_lines[v] = 1'b1;
            tick();
            check_held("R2 direct", v);
            check("R9 wake pulse", 64'(wake), 1);
            tick();
            check("R9 wake ends", 64'(wake), 0);
            vec_lines[v] = 1'b0;
            tick();
            check_idle("R7 release");
        end

        // R4/R5: sweep all ISA lines
        for (int n = 0; n < 16; n++) begin
            case (n)
                7: isa_vec = 'h22; 6: isa_vec = 'h27; 1: isa_vec = 'h29;
                12: isa_vec = 'h2A; 4: isa_vec = 'h2B; default: isa_vec = -1;
            endcase
            isa_lines[n] = 1'b1;
            tick();
            if (isa_vec >= 0) check_held("R4 isa map", isa_vec);
            else check("R5 unmapped isa", 64'(busy), 0);
            isa_lines[n] = 1'b0;
            tick();
            check_idle("R4 isa release");
        end

        // R6/R7: raise while busy is lost; only the held line releases
        vec_lines[5] = 1'b1;
        tick();
        vec_lines[10] = 1'b1;
        tick();
        check_held("R6 ignore", 5);
        vec_lines[10] = 1'b0;
        tick();
        check_held("R7 other low", 5);
        vec_lines[10] = 1'b1;
        tick();
        check_held("R6 second ignore", 5);
        vec_lines[5] = 1'b0;
        tick();
        check_idle("R7 held low");
        tick();
        check("R6 not replayed", 64'(busy), 0);
        vec_lines[10] = 1'b0;
        tick();

        // R10: simultaneous raises, lowest wins, losers discarded
        vec_lines[40] = 1'b1; vec_lines[30] = 1'b1; vec_lines[7] = 1'b1;
        tick();
        check_held("R10 lowest", 7);
        vec_lines[7] = 1'b0;
        tick();
        check_idle("R10 release");
        tick();
        check("R10 losers dropped", 64'(busy), 0);
        vec_lines = '0;
        tick();

        // R4: ISA and direct line share a vector
        isa_lines[4] = 1'b1;
        tick();
        check_held("R4 shared", 'h2B);
        vec_lines['h2B] = 1'b1;
        isa_lines[4] = 1'b0;
        tick();
        check_held("R4 shared held", 'h2B);
        vec_lines['h2B] = 1'b0;
        tick();
        check_idle("R4 shared release");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule